// File: doc/BRIEF.md
# Serial Register-Access Slave with Pulse-Triggered SPI Entry

This block lets an external bus master read and write a bank of 8-bit registers over a four-wire serial link. After reset it leaves the serial pins alone, because the device starts out driven by a different two-wire protocol engine that is outside this block. The select pin is shared with an address-strap function. The master switches the device into SPI mode by pulsing that pin low three times. The block counts the rising edges, enters SPI mode on the third, and stays there until the next reset.

In SPI mode each selected phase starts with a command byte. The write command (0xD4) is followed by a starting subaddress and then any number of data bytes. These are stored at ascending subaddresses through a one-cycle write strobe on the register-bank port. To read, the master first runs a write-command phase that carries only the subaddress. It then deselects, selects again, and sends the read command (0xD5). The block fetches registers from the stored subaddress upward and shifts them out on MISO.

SCLK, MOSI and select are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. SCLK must therefore run at no more than a quarter of the system clock. The register bank answers a read combinationally from the address the block presents.

Top module: `spi_regport`

## Requirements
- R1: After reset, spi_mode_o is 0, miso_o is 0, and neither reg_we_o nor reg_re_o is asserted.
- R2: spi_mode_o rises after the third rising edge of csel_i since reset. Before that, serial traffic produces no register strobe.
- R3: Once set, spi_mode_o stays 1 whatever further activity appears on csel_i.
- R4: In a selected phase whose first byte is 0xD4, the second byte loads the subaddress pointer. Each later complete byte is written with one reg_we_o strobe at the pointer, and the pointer then steps up by one. MOSI is sampled on SCLK rising edges, MSB first.
- R5: In a selected phase whose first byte is 0xD5, the block reads registers from the pointer upward. Each register is fetched with one reg_re_o strobe and shifted out on miso_o MSB first, and miso_o changes on SCLK falling edges. The first data bit appears on the falling edge that follows the last command bit.
- R6: The subaddress pointer is 8 bits wide, and auto-increment wraps it from 0xFF to 0x00.
- R7: A command byte other than 0xD4 or 0xD5 makes the block ignore the rest of that selected phase. There are no strobes, and miso_o stays 0.
- R8: A byte left incomplete when csel_i rises is discarded and never reaches the register bank.
- R9: miso_o is 0 whenever no read phase is in progress.
- R10: The pointer keeps its value while csel_i is high, so a read phase continues from the subaddress set by the preceding write-command phase.
- R11: A single register can be written or read alone by transferring exactly one data byte after the subaddress or command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| mosi_i | input | 1 | Serial data from the master |
| csel_i | input | 1 | Shared select / mode-entry pin, low selects |
| miso_o | output | 1 | Serial read data to the master |
| spi_mode_o | output | 1 | High once SPI mode has been entered |
| reg_addr_o | output | 8 | Register-bank address (subaddress pointer) |
| reg_wdata_o | output | 8 | Register-bank write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read strobe, data taken from reg_rdata_i in that cycle |
| reg_rdata_i | input | 8 | Register-bank read data for reg_addr_o |

## Verification
The in-module assertions guard the rules that hold on every cycle. SPI mode never drops once set. No strobe appears before mode entry or after an unknown command. MISO is held low outside a read. Each write strobe advances the pointer by one and wraps it at 0xFF, and write and read strobes never coincide. Only the bench scenarios can show the behaviour that needs the whole serial framing: the exact count of select pulses, the MSB-first bit order on both lines, the pointer carried across the deselect between the two phases of a read, and the dropped partial byte. The bench shows these by comparing bank contents and captured MISO bytes with its own register model.

// File: rtl/spi_regport_pkg.sv
// Package: shared constants and phase type for the serial register slave.
// Assumes 8-bit registers and an 8-bit subaddress space.
package spi_regport_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          BITCNT_W  = $clog2(BYTE_W);
    localparam logic [7:0]  CMD_WRITE = 8'hD4;
    localparam logic [7:0]  CMD_READ  = 8'hD5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } xfer_phase_e;
endpackage

// File: rtl/spi_edge_sync.sv
// Module: multi-bit synchroniser with edge detection.
// Each bit passes through STAGES flops, and one more flop of history gives
// rise and fall pulses one system clock wide. Assumes the inputs are slow
// compared to clk. RESET_LEVEL sets the idle level so that reset itself
// produces no edge.
module spi_edge_sync #(
    parameter int              WIDTH       = 3,
    parameter int              STAGES      = 2,
    parameter logic [WIDTH-1:0] RESET_LEVEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES:0] pipe;

        // Shift the raw input through the synchroniser and history flops.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {(STAGES+1){RESET_LEVEL[b]}};
            else        pipe <= {pipe[STAGES-1:0], din[b]};
        end

        assign level[b] = pipe[STAGES-1];
        assign rise[b]  = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[b]  = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/spi_mode_detect.sv
// Module: counts select rising edges after reset and latches SPI mode on
// the ENTRY_EDGES-th edge. Only reset clears the mode.
module spi_mode_detect #(
    parameter int ENTRY_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_rise,
    output logic mode_o
);
    localparam int CNT_W = $clog2(ENTRY_EDGES + 1);

    logic [CNT_W-1:0] edge_cnt;

    // Count select rising edges until the entry threshold, then hold the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            mode_o   <= 1'b0;
        end else if (!mode_o && sel_rise) begin
            if (edge_cnt == CNT_W'(ENTRY_EDGES - 1)) mode_o <= 1'b1;
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> mode_o);
endmodule

// File: rtl/spi_xfer_engine.sv
// Module: byte framing, command decode, subaddress pointer and read shifter.
// Works on synchronised levels and edge pulses. Assumes at least two system
// clocks between an SCLK rise and the next fall, so a read fetch finishes
// before the next bit has to be driven. The bank answers reads in the
// strobe cycle.
module spi_xfer_engine
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              sel_level,
    input  logic              sel_rise,
    input  logic              sel_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_level,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              miso_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              re_o
);
    xfer_phase_e         phase;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]   rx_sr;
    logic [BYTE_W-1:0]   tx_sr;
    logic [BYTE_W-1:0]   ptr;
    logic [BYTE_W-1:0]   rx_byte;
    logic                byte_done;

    assign rx_byte   = {rx_sr, mosi_level};
    assign byte_done = sclk_rise && (bit_cnt == BITCNT_W'(BYTE_W - 1));
    assign addr_o    = ptr;

    // Frame bits into bytes, decode commands and drive the bank strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            ptr     <= '0;
            wdata_o <= '0;
            we_o    <= 1'b0;
            re_o    <= 1'b0;
        end else begin
            we_o <= 1'b0;
            re_o <= 1'b0;
            if (we_o) ptr <= ptr + 1'b1;
            if (!mode_i || sel_rise) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
            end else if (sel_fall) begin
                phase   <= PH_CMD;
                bit_cnt <= '0;
            end else if (sclk_rise && phase != PH_IDLE) begin
                rx_sr   <= rx_byte[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    unique case (phase)
                        PH_CMD: begin
                            if (rx_byte == CMD_WRITE) begin
                                phase <= PH_ADDR;
                            end else if (rx_byte == CMD_READ) begin
                                phase <= PH_RDATA;
                                re_o  <= 1'b1;
                            end else begin
                                phase <= PH_IGNORE;
                            end
                        end
                        PH_ADDR: begin
                            ptr   <= rx_byte;
                            phase <= PH_WDATA;
                        end
                        PH_WDATA: begin
                            wdata_o <= rx_byte;
                            we_o    <= 1'b1;
                        end
                        PH_RDATA: begin
                            ptr  <= ptr + 1'b1;
                            re_o <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Load fetched read data, then shift it out one bit per SCLK fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                              tx_sr <= '0;
        else if (re_o)                           tx_sr <= rdata_i;
        else if (sclk_fall && phase == PH_RDATA) tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end

    // Drive MISO on SCLK falls during a read, and hold it low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                              miso_o <= 1'b0;
        else if (phase != PH_RDATA || sel_level) miso_o <= 1'b0;
        else if (sclk_fall)                      miso_o <= tx_sr[BYTE_W-1];
    end

    assert_no_strobe_premode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> (!we_o && !re_o));
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> (ptr == BYTE_W'($past(ptr) + 1)));
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_o && re_o));
    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && ptr == 8'hFF) |=> (ptr == 8'h00));
    assert_ignore_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |=> (!we_o && !re_o));
    assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RDATA) |=> !miso_o);
endmodule

// File: rtl/spi_regport.sv
// Module: top of the serial register-access slave. It synchronises the
// serial pins, detects the pulse pattern that enters SPI mode, and runs the
// byte engine against the register-bank port. Assumes SCLK is at most
// clk/4 and idles low, and that csel_i idles high.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_EDGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              csel_i,
    output logic              miso_o,
    output logic              spi_mode_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    localparam int PIN_N = 3;
    localparam int IDX_SCLK = 0;
    localparam int IDX_MOSI = 1;
    localparam int IDX_SEL  = 2;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;

    spi_edge_sync #(
        .WIDTH       (PIN_N),
        .STAGES      (SYNC_STAGES),
        .RESET_LEVEL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({csel_i, mosi_i, sclk_i}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    spi_mode_detect #(
        .ENTRY_EDGES (ENTRY_EDGES)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_rise (pin_rise[IDX_SEL]),
        .mode_o   (spi_mode_o)
    );

    spi_xfer_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (spi_mode_o),
        .sel_level  (pin_lvl[IDX_SEL]),
        .sel_rise   (pin_rise[IDX_SEL]),
        .sel_fall   (pin_fall[IDX_SEL]),
        .sclk_rise  (pin_rise[IDX_SCLK]),
        .sclk_fall  (pin_fall[IDX_SCLK]),
        .mosi_level (pin_lvl[IDX_MOSI]),
        .rdata_i    (reg_rdata_i),
        .miso_o     (miso_o),
        .addr_o     (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .we_o       (reg_we_o),
        .re_o       (reg_re_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!spi_mode_o && !miso_o && !reg_we_o && !reg_re_o));
endmodule

// File: tb/spi_regport_tb_top.sv
// Bench: directed corner cases plus seeded random write/readback traffic,
// checked against a register model kept in the bench.
module spi_regport_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, mosi = 1'b0, csel = 1'b1;
    logic       miso, mode;
    logic [7:0] addr, wdata, rdata;
    logic       we, re;

    logic [7:0] bank    [256];
    logic [7:0] exp_mem [256];
    logic [7:0] txq [20];
    logic [7:0] rxq [20];
    int n_cmp = 0, n_bad = 0, we_cnt = 0, re_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_regport dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .csel_i(csel),
        .miso_o(miso), .spi_mode_o(mode), .reg_addr_o(addr), .reg_wdata_o(wdata),
        .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
    );

    assign rdata = bank[addr];

    // Register bank model: stores writes and counts strobes.
    always @(posedge clk) begin
        if (we) begin bank[addr] <= wdata; we_cnt <= we_cnt + 1; end
        if (re) re_cnt <= re_cnt + 1;
    end

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        return exp_mem[a];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Select, shift n bytes from txq (plus cut_bits of txq[n]), deselect.
    task automatic run_xfer(input int n, input int cut_bits);
        tick(1); csel = 1'b0; tick(HALF);
        for (int k = 0; k < n + (cut_bits > 0 ? 1 : 0); k++) begin
            logic [7:0] got = 8'h00;
            int nb = (k < n) ? 8 : cut_bits;
            for (int i = 7; i >= 8 - nb; i--) begin
                mosi = txq[k][i]; tick(HALF);
                got[i] = miso;
                sclk = 1'b1; tick(HALF);
                sclk = 1'b0;
            end
            rxq[k] = got;
        end
        tick(HALF); csel = 1'b1; mosi = 1'b0; tick(2 * HALF);
    endtask

    task automatic spi_write(input logic [7:0] a, input int n);
        txq[0] = 8'hD4; txq[1] = a;
        for (int k = 0; k < n; k++) exp_mem[8'(a + k)] = txq[2 + k];
        run_xfer(n + 2, 0);
    endtask

    // Two-phase read: set subaddress, then read n bytes into rxq[1..n].
    task automatic spi_read(input logic [7:0] a, input int n);
        txq[0] = 8'hD4; txq[1] = a;
        run_xfer(2, 0);
        txq[0] = 8'hD5;
        for (int k = 1; k <= n; k++) txq[k] = 8'h00;
        run_xfer(n + 1, 0);
    endtask

    initial begin
        tick(150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int wc;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) begin bank[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
        tick(4); rst_n = 1'b1; tick(2);
        chk("R1 mode after reset", mode, 0);
        chk("R1 miso after reset", miso, 0);
        chk("R1 no strobes after reset", we_cnt + re_cnt, 0);

        // Pulse 1 carries a full write frame: must not reach the bank (R2).
        txq[0] = 8'hD4; txq[1] = 8'h10; txq[2] = 8'hAA;
        run_xfer(3, 0);
        chk("R2 no strobe before mode", we_cnt + re_cnt, 0);
        chk("R2 mode after 1 edge", mode, 0);
        csel = 1'b0; tick(HALF); csel = 1'b1; tick(2 * HALF);
        chk("R2 mode after 2 edges", mode, 0);
        csel = 1'b0; tick(HALF); csel = 1'b1; tick(2 * HALF);
        chk("R2 mode after 3 edges", mode, 1);

        // Burst write then two-phase read (R4, R5, R10).
        for (int k = 0; k < 4; k++) txq[2 + k] = 8'($urandom);
        spi_write(8'h20, 4);
        for (int k = 0; k < 4; k++) chk("R4 burst write bank", bank[8'h20 + k], model_rd(8'(8'h20 + k)));
        chk("R4 neighbour untouched", bank[8'h24], model_rd(8'h24));
        spi_read(8'h20, 4);
        for (int k = 1; k <= 4; k++) chk("R5 R10 burst read", rxq[k], model_rd(8'(8'h1F + k)));
        chk("R9 miso low during command byte", rxq[0], 0);

        // Single register write and read (R11).
        txq[2] = 8'h5A; wc = we_cnt;
        spi_write(8'h55, 1);
        chk("R11 single write count", we_cnt - wc, 1);
        chk("R11 single write value", bank[8'h55], 8'h5A);
        spi_read(8'h55, 1);
        chk("R11 single read", rxq[1], 8'h5A);

        // Wrap across 0xFF (R6).
        txq[2] = 8'h11; txq[3] = 8'h22; txq[4] = 8'h33;
        spi_write(8'hFE, 3);
        chk("R6 wrap write FF", bank[8'hFF], 8'h22);
        chk("R6 wrap write 00", bank[8'h00], 8'h33);
        spi_read(8'hFF, 2);
        chk("R6 wrap read FF", rxq[1], 8'h22);
        chk("R6 wrap read 00", rxq[2], 8'h33);

        // Unknown command (R7).
        wc = we_cnt + re_cnt;
        txq[0] = 8'h3C; txq[1] = 8'h30; txq[2] = 8'hFF; txq[3] = 8'hFF;
        run_xfer(4, 0);
        chk("R7 no strobes after bad command", we_cnt + re_cnt, wc);
        chk("R7 miso low after bad command", rxq[2] | rxq[3], 0);
        chk("R7 bank untouched", bank[8'h30], model_rd(8'h30));

        // Partial byte cut by deselect (R8), MISO idle during write (R9).
        wc = we_cnt;
        txq[0] = 8'hD4; txq[1] = 8'h40; txq[2] = 8'hC3; txq[3] = 8'hFF;
        exp_mem[8'h40] = 8'hC3;
        run_xfer(3, 5);
        chk("R8 only whole byte written", we_cnt - wc, 1);
        chk("R8 partial byte dropped", bank[8'h41], model_rd(8'h41));
        chk("R9 miso low during write", rxq[1] | rxq[2], 0);

        // Extra select pulses keep the mode (R3).
        for (int p = 0; p < 3; p++) begin csel = 1'b0; tick(HALF); csel = 1'b1; tick(HALF); end
        tick(HALF);
        chk("R3 mode sticky", mode, 1);

        // Seeded random write/readback traffic (R4, R5).
        for (int it = 0; it < 20; it++) begin
            logic [7:0] a = 8'($urandom);
            int n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) txq[2 + k] = 8'($urandom);
            spi_write(a, n);
            spi_read(a, n);
            for (int k = 1; k <= n; k++) chk("R5 random readback", rxq[k], model_rd(8'(a + k - 1)));
        end
        tick(4);
        chk("R9 miso idle at end", miso, 0);
        report();
    end
endmodule